// File: doc/BRIEF.md
# Bus Error Exception Escalation Controller

This controller sits between the instruction-side and data-side memory interfaces and the pipeline's exception logic. Each memory interface pulses an uncorrectable-error indication. The controller decides if that error becomes an instruction bus exception, a data bus exception, or a fatal stop. The decision depends on the exception-enable bit of the machine status register and on an internal flag that records whether an exception handler is currently running.

An accepted error produces a one-cycle exception request with a cause code. A second bus error that arrives while a handler is already active does not nest. Instead it sets a halt request and an external error line, and both stay set until reset.

The controller also ensures that no instruction corrupted by an uncorrectable error can execute while exceptions are disabled. In that case an instruction-side error raises a hold that stalls issue. The held error is turned into an exception as soon as exceptions are enabled again. All outputs come from registers, so every decision shows one clock after the inputs that caused it. Every port is a plain control or status pin; there is no data stream and therefore no back-pressure.

Top module: `bus_err_escalator`

## Requirements
- R1: While reset is applied, and in the first cycle after it is released, every output is 0: exc_req_o, exc_cause_o, in_exc_o, dlost_o, hold_o, halt_o and ext_err_o.
- R2: Suppose exceptions are enabled, no handler is active and the block is not halted. An instruction error (ierr_i) then gives, one clock later, exc_req_o=1 with exc_cause_o=3'b011, and in_exc_o=1.
- R3: Under the same conditions, a data error alone (derr_i) gives, one clock later, exc_req_o=1 with exc_cause_o=3'b100, and in_exc_o=1.
- R4: If both errors arrive in the same cycle and an exception is taken, the instruction cause 3'b011 wins and dlost_o becomes 1. dlost_o holds until a return pulse (exc_ret_i) clears it.
- R5: With exc_en_i=0, a data error has no effect on any output. An instruction error sets hold_o one clock later.
- R6: hold_o stays set while exc_en_i=0. In the first cycle with exc_en_i=1, the held error is treated as an instruction error, and hold_o drops at that same edge.
- R7: Suppose exceptions are enabled and in_exc_o=1. Any bus error then sets halt_o and ext_err_o one clock later, and no exception request is issued.
- R8: halt_o and ext_err_o stay set until reset. Once halted, no further exception request, hold or status change occurs, and return pulses are ignored.
- R9: A return pulse clears in_exc_o one clock later. A bus error in the same cycle as the return still sees the handler as active and escalates to a halt.
- R10: exc_req_o is never high in two consecutive cycles. exc_cause_o is 3'b000 whenever exc_req_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ierr_i | input | 1 | Uncorrectable error on the instruction memory interface |
| derr_i | input | 1 | Uncorrectable error on the data memory interface |
| exc_en_i | input | 1 | Exception-enable bit of the machine status register |
| exc_ret_i | input | 1 | Return-from-exception pulse |
| exc_req_o | output | 1 | One-cycle exception request |
| exc_cause_o | output | 3 | Cause: 3'b011 instruction bus, 3'b100 data bus, 3'b000 idle |
| in_exc_o | output | 1 | Exception handler active |
| dlost_o | output | 1 | A data error was dropped in favour of an instruction error |
| hold_o | output | 1 | Issue stall for an instruction error seen while exceptions were disabled |
| halt_o | output | 1 | Sticky halt request |
| ext_err_o | output | 1 | Sticky external error line |

## Verification
A wrong in-progress flag shows up at the ports within one clock. Either a second error produces a request where a halt was due, or a halt appears where a request was due. A lost pending hold shows up in the first enabled cycle as a missing 3'b011 request. A stale dlost or halt bit is seen on the very next sampled cycle, because the bench compares every output against its own model each clock under random error, enable and return traffic. Resets are spread through the run, so sticky states are exercised from fresh starts many times.

// File: rtl/besc_pkg.sv
package besc_pkg;
  localparam int CAUSE_W = 3;
  typedef logic [CAUSE_W-1:0] cause_t;
  localparam cause_t CAUSE_NONE = 3'b000;
  localparam cause_t CAUSE_IBUS = 3'b011;
  localparam cause_t CAUSE_DBUS = 3'b100;
endpackage

// File: rtl/besc_select.sv
module besc_select
  import besc_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   ierr,
  input  logic   ipend,
  input  logic   derr,
  input  logic   exc_en,
  input  logic   in_exc,
  input  logic   halted,
  output logic   take,
  output logic   fatal,
  output logic   fire_i,
  output logic   collide,
  output cause_t cause
);
  logic fire_d, any_err;

  always_comb begin
    fire_i  = exc_en & (ierr | ipend) & ~halted;
    fire_d  = exc_en & derr & ~halted;
    any_err = fire_i | fire_d;
    fatal   = any_err & in_exc;
    take    = any_err & ~in_exc;
    collide = take & fire_i & fire_d;
    cause   = take ? (fire_i ? CAUSE_IBUS : CAUSE_DBUS) : CAUSE_NONE;
  end

  assert_no_take_halted_R8: assert property (@(posedge clk) disable iff (!rst_n)
    halted |-> !take && !fatal);
  assert_take_fatal_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(take && fatal));
endmodule

// File: rtl/besc_excflag.sv
module besc_excflag (
  input  logic clk,
  input  logic rst_n,
  input  logic take,
  input  logic collide,
  input  logic ret,
  input  logic halted,
  output logic in_exc,
  output logic dlost
);
  logic ret_ok;
  assign ret_ok = ret & ~halted;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      in_exc <= 1'b0;
      dlost  <= 1'b0;
    end else begin
      if (take)        in_exc <= 1'b1;
      else if (ret_ok) in_exc <= 1'b0;
      if (collide)     dlost <= 1'b1;
      else if (ret_ok) dlost <= 1'b0;
    end
  end

  assert_ret_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ret && !take && !halted) |=> !in_exc);
  assert_dlost_needs_exc_R4: assert property (@(posedge clk) disable iff (!rst_n)
    dlost |-> in_exc);
endmodule

// File: rtl/besc_pend.sv
module besc_pend (
  input  logic clk,
  input  logic rst_n,
  input  logic ierr,
  input  logic exc_en,
  input  logic halted,
  input  logic consume,
  output logic pend
);
  always_ff @(posedge clk) begin
    if (!rst_n)                       pend <= 1'b0;
    else if (!exc_en && ierr && !halted) pend <= 1'b1;
    else if (consume)                 pend <= 1'b0;
  end

  assert_hold_sets_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!exc_en && ierr && !halted) |=> pend);
  assert_hold_keeps_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (pend && !exc_en) |=> pend);
endmodule

// File: rtl/besc_fatal.sv
module besc_fatal (
  input  logic clk,
  input  logic rst_n,
  input  logic fatal,
  output logic halted
);
  always_ff @(posedge clk) begin
    if (!rst_n)     halted <= 1'b0;
    else if (fatal) halted <= 1'b1;
  end

  assert_halt_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> halted);
endmodule

// File: rtl/bus_err_escalator.sv
module bus_err_escalator
  import besc_pkg::*;
(
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ierr_i,
  input  logic         derr_i,
  input  logic         exc_en_i,
  input  logic         exc_ret_i,
  output logic         exc_req_o,
  output logic [2:0]   exc_cause_o,
  output logic         in_exc_o,
  output logic         dlost_o,
  output logic         hold_o,
  output logic         halt_o,
  output logic         ext_err_o
);
  logic   take, fatal, fire_i, collide, halted, in_exc, pend;
  cause_t cause;
  logic   req_q;
  cause_t cause_q;

  besc_select u_sel (
    .clk(clk), .rst_n(rst_n), .ierr(ierr_i), .ipend(pend), .derr(derr_i),
    .exc_en(exc_en_i), .in_exc(in_exc), .halted(halted),
    .take(take), .fatal(fatal), .fire_i(fire_i), .collide(collide), .cause(cause)
  );

  besc_excflag u_flag (
    .clk(clk), .rst_n(rst_n), .take(take), .collide(collide), .ret(exc_ret_i),
    .halted(halted), .in_exc(in_exc), .dlost(dlost_o)
  );

  besc_pend u_pend (
    .clk(clk), .rst_n(rst_n), .ierr(ierr_i), .exc_en(exc_en_i), .halted(halted),
    .consume((take & fire_i) | fatal), .pend(pend)
  );

  besc_fatal u_fatal (
    .clk(clk), .rst_n(rst_n), .fatal(fatal), .halted(halted)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req_q   <= 1'b0;
      cause_q <= CAUSE_NONE;
    end else begin
      req_q   <= take;
      cause_q <= cause;
    end
  end

  assign exc_req_o   = req_q;
  assign exc_cause_o = cause_q;
  assign in_exc_o    = in_exc;
  assign hold_o      = pend;
  assign halt_o      = halted;
  assign ext_err_o   = halted;

  assert_req_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    exc_req_o |=> !exc_req_o);
  assert_cause_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !exc_req_o |-> exc_cause_o == 3'b000);
  assert_inst_priority_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_en_i && ierr_i && derr_i && !in_exc_o && !halt_o)
      |=> (exc_req_o && exc_cause_o == 3'b011 && dlost_o));
  assert_nested_halts_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_en_i && (ierr_i || derr_i) && in_exc_o) |=> (halt_o && ext_err_o && !exc_req_o));
  assert_data_ignored_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!exc_en_i && !ierr_i && !hold_o) |=> !exc_req_o && !halt_o || $past(halt_o));
endmodule

// File: tb/test_bus_err_escalator.sv
module test_bus_err_escalator;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ierr_i = 0, derr_i = 0, exc_en_i = 0, exc_ret_i = 0;
  logic exc_req_o, in_exc_o, dlost_o, hold_o, halt_o, ext_err_o;
  logic [2:0] exc_cause_o;

  always #10 clk = ~clk;

  bus_err_escalator i_bus_err_escalator (
    .clk(clk), .rst_n(rst_n), .ierr_i(ierr_i), .derr_i(derr_i), .exc_en_i(exc_en_i),
    .exc_ret_i(exc_ret_i), .exc_req_o(exc_req_o), .exc_cause_o(exc_cause_o),
    .in_exc_o(in_exc_o), .dlost_o(dlost_o), .hold_o(hold_o), .halt_o(halt_o),
    .ext_err_o(ext_err_o)
  );

  int checks = 0, failures = 0;
  logic m_req, m_inx, m_dl, m_pend, m_hlt;
  logic [2:0] m_cause;

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic cmp_all(input string req);
    chk(req, "exc_req_o", exc_req_o, m_req);
    chk(req, "exc_cause_o", exc_cause_o, m_cause);
    chk(req, "in_exc_o", in_exc_o, m_inx);
    chk(req, "dlost_o", dlost_o, m_dl);
    chk(req, "hold_o", hold_o, m_pend);
    chk(req, "halt_o", halt_o, m_hlt);
    chk(req, "ext_err_o", ext_err_o, m_hlt);
  endtask

  function automatic logic [2:0] cause_of(input logic fi);
    return fi ? 3'b011 : 3'b100;
  endfunction

  // Drive inputs for one clock, advance the model, compare after the edge.
  task automatic cyc(input logic ie, input logic de, input logic en, input logic rt,
                     input string req);
    logic fi, fd, fatal, take, retok;
    ierr_i = ie; derr_i = de; exc_en_i = en; exc_ret_i = rt;
    fi = en & (ie | m_pend) & ~m_hlt;
    fd = en & de & ~m_hlt;
    fatal = (fi | fd) & m_inx;
    take = (fi | fd) & ~m_inx;
    retok = rt & ~m_hlt;
    m_req = take;
    m_cause = take ? cause_of(fi) : 3'b000;
    if (take & fi & fd) m_dl = 1'b1; else if (retok) m_dl = 1'b0;
    if (!en & ie & !m_hlt) m_pend = 1'b1; else if ((take & fi) | fatal) m_pend = 1'b0;
    if (take) m_inx = 1'b1; else if (retok) m_inx = 1'b0;
    if (fatal) m_hlt = 1'b1;
    @(posedge clk);
    @(negedge clk);
    cmp_all(req);
  endtask

  task automatic do_reset();
    rst_n = 1'b0; ierr_i = 0; derr_i = 0; exc_en_i = 0; exc_ret_i = 0;
    m_req = 0; m_cause = 0; m_inx = 0; m_dl = 0; m_pend = 0; m_hlt = 0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    cmp_all("R1");
    rst_n = 1'b1;
  endtask

  initial begin
    #(20 * 200000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    @(negedge clk);
    do_reset();
    cyc(0, 0, 0, 0, "R1");
    // R2: instruction error
    cyc(1, 0, 1, 0, "R2");
    chk("R2", "cause", exc_cause_o, 3'b011);
    cyc(0, 0, 1, 0, "R10");
    chk("R10", "req pulse", exc_req_o, 0);
    cyc(0, 0, 1, 1, "R9");
    chk("R9", "in_exc cleared", in_exc_o, 0);
    // R3: data error
    cyc(0, 1, 1, 0, "R3");
    chk("R3", "cause", exc_cause_o, 3'b100);
    cyc(0, 0, 1, 1, "R9");
    // R4: simultaneous
    cyc(1, 1, 1, 0, "R4");
    chk("R4", "dlost", dlost_o, 1);
    chk("R4", "cause", exc_cause_o, 3'b011);
    cyc(0, 0, 1, 1, "R4");
    chk("R4", "dlost cleared", dlost_o, 0);
    // R5/R6: disabled
    cyc(0, 1, 0, 0, "R5");
    chk("R5", "data ignored req", exc_req_o, 0);
    chk("R5", "data ignored hold", hold_o, 0);
    cyc(1, 0, 0, 0, "R5");
    chk("R5", "hold set", hold_o, 1);
    cyc(0, 0, 0, 0, "R6");
    chk("R6", "hold kept", hold_o, 1);
    cyc(0, 0, 1, 0, "R6");
    chk("R6", "held becomes exc", exc_cause_o, 3'b011);
    chk("R6", "hold dropped", hold_o, 0);
    // R9/R7: error on return cycle escalates
    cyc(0, 1, 1, 1, "R9");
    chk("R7", "halt", halt_o, 1);
    chk("R7", "no req", exc_req_o, 0);
    // R8: sticky
    cyc(1, 1, 1, 1, "R8");
    cyc(1, 0, 0, 0, "R8");
    chk("R8", "still halted", ext_err_o, 1);
    chk("R8", "no hold", hold_o, 0);
    do_reset();
    // random traffic with periodic resets
    for (int n = 0; n < 4000; n++) begin
      logic ie, de, en, rt;
      if (n % 60 == 59) do_reset();
      ie = ($urandom % 6) == 0;
      de = ($urandom % 6) == 0;
      en = ($urandom % 4) != 0;
      rt = ($urandom % 3) == 0;
      cyc(ie, de, en, rt, "R10");
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule